// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is the target side of an I2C bus port with a fixed 7-bit own address. It samples the open-drain SCL and SDA lines through a two-flop synchroniser, recognises START and STOP, compares the received address with its own, and acknowledges. It then either receives bytes from the bus controller or sends bytes to it. Only one byte register sits between the bus and the host CPU. So after every received byte, and before every byte to be sent, the block holds SCL low until the host has serviced that register.

The host reaches the block through a small synchronous register port: single-cycle read and write strobes, a 3-bit register index, and combinational read data. Three events (data, START, STOP) each have a raw flag, a mask bit and a masked view. Writing ones to the clear register drops flags, and `irq` is the OR of the masked flags. Two enables, a run bit and a configuration-level target-function bit, must both be set before the block responds on the bus.

Top module: `i2c_target_stretch`

## Requirements
- R1: With both enables set, the target pulls SDA low during the ninth clock after an address byte whose upper seven bits equal the own-address register (index 0, bits 6:0). For any other address it leaves SDA released.
- R2: Unless both run (index 1, bit 0) and target function (index 7, bit 0) are 1, the target acknowledges no address and never pulls either line.
- R3: Address bit 0 = 1 selects a read. After the address ACK, status bit 1 (index 2) reads 1 and SCL is held low until the host writes the data register (index 3). That byte is then sent MSB first.
- R4: After each received data byte, the target drives the ACK and sets status bit 0. It holds SCL low until the host reads the data register, then releases SCL.
- R5: Status bit 2 reads 1 only while the receive request is pending for the first data byte after the address. Reading the data register clears it. Later bytes leave it 0.
- R6: Reading the data register returns the last received byte, and writing it loads the next byte to send. The value persists until the next host write or bus receive.
- R7: If the controller ACKs a sent byte, a new transmit request is raised. If it NACKs, the target releases SDA, raises no request and stays silent until the next START.
- R8: Raw flags (index 5) are bit 0 data (byte received or transmit request), bit 1 START and bit 2 STOP. They are set only while both enables are 1.
- R9: The masked view (index 6 read) equals raw AND mask (index 4). `irq` is 1 exactly when any masked bit is 1.
- R10: Writing index 6 clears every raw flag whose write-data bit is 1 and leaves the others alone. An event in the same cycle as its clear wins, and the flag stays set.
- R11: After reset, every register index reads 0, `irq` is 0 and both line pulls are off.
- R12: Clearing either enable mid-transfer releases both lines on the next clock and drops any pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line level as seen at the pad |
| sda_in | input | 1 | SDA line level as seen at the pad |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (ACK or data 0) |
| reg_wr | input | 1 | Host write strobe, one cycle |
| reg_rd | input | 1 | Host read strobe, one cycle |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the indexed register |
| irq | output | 1 | OR of the masked event flags |

## Verification
A host write to the clear register can land in the same clock edge at which a START is detected. This pits the clear path against the set path of the same raw flag. The bench starts a START by dropping SDA while SCL is high. It then counts the synchroniser and edge-detector stages, so that the clear strobe for the START bit arrives exactly at the edge that records the event. It then expects the START flag to read 1. A lone clear with no event is checked separately and must drop the flag.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared register indices, event bit positions and the byte
// engine state encoding for the I2C target.
package i2c_tgt_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RI_OWN  = 3'd0;
    localparam logic [REG_AW-1:0] RI_CTRL = 3'd1;
    localparam logic [REG_AW-1:0] RI_STAT = 3'd2;
    localparam logic [REG_AW-1:0] RI_DATA = 3'd3;
    localparam logic [REG_AW-1:0] RI_MASK = 3'd4;
    localparam logic [REG_AW-1:0] RI_RAW  = 3'd5;
    localparam logic [REG_AW-1:0] RI_MIS  = 3'd6;
    localparam logic [REG_AW-1:0] RI_CFG  = 3'd7;

    localparam int EV_DATA  = 0;
    localparam int EV_START = 1;
    localparam int EV_STOP  = 2;
    localparam int EV_NUM   = 3;

    typedef enum logic [3:0] {
        TS_IDLE,
        TS_ADDR,
        TS_ADDR_ACK,
        TS_RX_BYTE,
        TS_RX_HOLD,
        TS_RX_ACK,
        TS_TX_HOLD,
        TS_TX_SETUP,
        TS_TX_BYTE,
        TS_TX_ACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Module: i2c_tgt_sync
// Brings SCL and SDA into the clk domain through STAGES flops and derives
// SCL edges plus START/STOP strobes from one further delayed copy.
// Assumes: lines idle high; the bus changes far slower than clk.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ch, sda_ch;
    logic              scl_q, sda_q;

    // Shift the raw pad levels through the synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ch <= '1;
            sda_ch <= '1;
        end else begin
            scl_ch <= {scl_ch[STAGES-2:0], scl_in};
            sda_ch <= {sda_ch[STAGES-2:0], sda_in};
        end
    end

    assign scl_s = scl_ch[STAGES-1];
    assign sda_s = sda_ch[STAGES-1];

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_engine.sv
// Module: i2c_tgt_engine
// Bit-level target state machine: address match, ACK, byte receive and
// transmit, and SCL stretching while the host owes a data-register access.
// Assumes: synchronised inputs and strobes from i2c_tgt_sync; host_rd and
// host_wr are single-cycle data-register strobes.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enabled,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              rx_pend,
    output logic              tx_pend,
    output logic              first_flag,
    output logic              rx_done,
    output logic              tx_need,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int SET_W = $clog2(SETUP_CYC + 1);
    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(DATA_W - 1);
    localparam logic [SET_W-1:0] SET_LAST  = SET_W'(SETUP_CYC - 1);

    tgt_state_e        state_q;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SET_W-1:0]  set_cnt;
    logic              is_read;
    logic              first_pend;
    logic              acked;

    // Walk the bus protocol one synchronised SCL edge at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= TS_IDLE;
            shreg      <= '0;
            bit_cnt    <= '0;
            set_cnt    <= '0;
            is_read    <= 1'b0;
            first_pend <= 1'b0;
            acked      <= 1'b0;
            sda_pull   <= 1'b0;
            rx_pend    <= 1'b0;
            tx_pend    <= 1'b0;
            first_flag <= 1'b0;
            rx_done    <= 1'b0;
            tx_need    <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            tx_need <= 1'b0;
            if (!enabled) begin
                state_q    <= TS_IDLE;
                sda_pull   <= 1'b0;
                rx_pend    <= 1'b0;
                tx_pend    <= 1'b0;
                first_flag <= 1'b0;
            end else if (stop_det) begin
                state_q  <= TS_IDLE;
                sda_pull <= 1'b0;
            end else if (start_det) begin
                state_q  <= TS_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state_q)
                    TS_ADDR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[DATA_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == BITS_FULL) begin
                            if (shreg[DATA_W-1 -: ADDR_W] == own_addr) begin
                                sda_pull <= 1'b1;
                                is_read  <= shreg[0];
                                state_q  <= TS_ADDR_ACK;
                            end else begin
                                state_q <= TS_IDLE;
                            end
                        end
                    end
                    TS_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            if (is_read) begin
                                tx_pend <= 1'b1;
                                tx_need <= 1'b1;
                                state_q <= TS_TX_HOLD;
                            end else begin
                                bit_cnt    <= '0;
                                first_pend <= 1'b1;
                                state_q    <= TS_RX_BYTE;
                            end
                        end
                    end
                    TS_RX_BYTE: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[DATA_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == BITS_FULL) begin
                            rx_done    <= 1'b1;
                            rx_pend    <= 1'b1;
                            first_flag <= first_pend;
                            first_pend <= 1'b0;
                            sda_pull   <= 1'b1;
                            state_q    <= TS_RX_HOLD;
                        end
                    end
                    TS_RX_HOLD: begin
                        if (host_rd) begin
                            rx_pend    <= 1'b0;
                            first_flag <= 1'b0;
                            state_q    <= TS_RX_ACK;
                        end
                    end
                    TS_RX_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            state_q  <= TS_RX_BYTE;
                        end
                    end
                    TS_TX_HOLD: begin
                        if (host_wr) begin
                            shreg    <= host_wdata;
                            sda_pull <= ~host_wdata[DATA_W-1];
                            tx_pend  <= 1'b0;
                            set_cnt  <= '0;
                            state_q  <= TS_TX_SETUP;
                        end
                    end
                    TS_TX_SETUP: begin
                        if (set_cnt == SET_LAST) begin
                            bit_cnt <= '0;
                            state_q <= TS_TX_BYTE;
                        end else begin
                            set_cnt <= set_cnt + 1'b1;
                        end
                    end
                    TS_TX_BYTE: begin
                        if (scl_fall) begin
                            if (bit_cnt == BITS_LAST) begin
                                sda_pull <= 1'b0;
                                state_q  <= TS_TX_ACK;
                            end else begin
                                shreg    <= {shreg[DATA_W-2:0], 1'b0};
                                sda_pull <= ~shreg[DATA_W-2];
                                bit_cnt  <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    TS_TX_ACK: begin
                        if (scl_rise) begin
                            acked <= ~sda_s;
                        end else if (scl_fall) begin
                            if (acked) begin
                                tx_pend <= 1'b1;
                                tx_need <= 1'b1;
                                state_q <= TS_TX_HOLD;
                            end else begin
                                state_q <= TS_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_pull = (state_q == TS_RX_HOLD) || (state_q == TS_TX_HOLD) ||
                      (state_q == TS_TX_SETUP);
    assign rx_byte  = shreg;

endmodule

// File: rtl/i2c_tgt_regs.sv
// Module: i2c_tgt_regs
// Host-visible registers: own address, enables, data byte, status, and the
// raw/mask/masked/clear event flags.
// Assumes: single-cycle reg_wr/reg_rd strobes; read data is combinational.
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_pend,
    input  logic              tx_pend,
    input  logic              first_flag,
    input  logic              rx_done,
    input  logic              tx_need,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              start_det,
    input  logic              stop_det,
    output logic [ADDR_W-1:0] own_addr,
    output logic              enabled,
    output logic              host_wr,
    output logic              host_rd,
    output logic [EV_NUM-1:0] evt_raw,
    output logic [EV_NUM-1:0] evt_mask
);
    logic              run_q;
    logic              tfe_q;
    logic [DATA_W-1:0] data_q;
    logic [EV_NUM-1:0] evt_set;
    logic [EV_NUM-1:0] raw_nxt;
    logic              clr_wr;

    assign enabled = run_q & tfe_q;
    assign host_wr = reg_wr && (reg_addr == RI_DATA);
    assign host_rd = reg_rd && (reg_addr == RI_DATA);
    assign clr_wr  = reg_wr && (reg_addr == RI_MIS);

    // Hold the configuration fields written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_addr <= '0;
            run_q    <= 1'b0;
            tfe_q    <= 1'b0;
            evt_mask <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RI_OWN:  own_addr <= reg_wdata[ADDR_W-1:0];
                RI_CTRL: run_q    <= reg_wdata[0];
                RI_CFG:  tfe_q    <= reg_wdata[0];
                RI_MASK: evt_mask <= reg_wdata[EV_NUM-1:0];
                default: ;
            endcase
        end
    end

    // Data byte: bus receive or host write, whichever came last.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (rx_done) data_q <= rx_byte;
        else if (host_wr) data_q <= reg_wdata;
    end

    // Per-event next value: set beats clear, clear needs a 1 in its bit.
    always_comb begin
        evt_set           = '0;
        evt_set[EV_DATA]  = rx_done | tx_need;
        evt_set[EV_START] = start_det & enabled;
        evt_set[EV_STOP]  = stop_det & enabled;
        for (int i = 0; i < EV_NUM; i++) begin
            if (evt_set[i])                 raw_nxt[i] = 1'b1;
            else if (clr_wr && reg_wdata[i]) raw_nxt[i] = 1'b0;
            else                             raw_nxt[i] = evt_raw[i];
        end
    end

    // Register the raw event flags.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_raw <= '0;
        else        evt_raw <= raw_nxt;
    end

    // Read multiplexer over all register indices.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RI_OWN:  reg_rdata = DATA_W'(own_addr);
            RI_CTRL: reg_rdata = DATA_W'(run_q);
            RI_STAT: reg_rdata = DATA_W'({first_flag & rx_pend, tx_pend, rx_pend});
            RI_DATA: reg_rdata = data_q;
            RI_MASK: reg_rdata = DATA_W'(evt_mask);
            RI_RAW:  reg_rdata = DATA_W'(evt_raw);
            RI_MIS:  reg_rdata = DATA_W'(evt_raw & evt_mask);
            RI_CFG:  reg_rdata = DATA_W'(tfe_q);
            default: reg_rdata = '0;
        endcase
        if (!reg_rd && !reg_wr && reg_addr == RI_DATA) reg_rdata = data_q;
    end

endmodule

// File: rtl/i2c_target_stretch.sv
// Module: i2c_target_stretch
// Top of the I2C target: synchroniser, byte engine and host registers.
// Assumes: external pull-ups; scl_pull/sda_pull drive open-drain pads.
module i2c_target_stretch
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SETUP_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              enabled, host_wr, host_rd;
    logic              rx_pend, tx_pend, first_flag, rx_done, tx_need;
    logic [DATA_W-1:0] rx_byte;
    logic [ADDR_W-1:0] own_addr;
    logic [EV_NUM-1:0] evt_raw, evt_mask;
    logic              scl_s_unused;

    assign scl_s_unused = scl_s;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .enabled(enabled), .own_addr(own_addr),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(reg_wdata), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .rx_pend(rx_pend), .tx_pend(tx_pend),
        .first_flag(first_flag), .rx_done(rx_done), .tx_need(tx_need),
        .rx_byte(rx_byte)
    );

    i2c_tgt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_pend(rx_pend), .tx_pend(tx_pend), .first_flag(first_flag),
        .rx_done(rx_done), .tx_need(tx_need), .rx_byte(rx_byte),
        .start_det(start_det), .stop_det(stop_det), .own_addr(own_addr),
        .enabled(enabled), .host_wr(host_wr), .host_rd(host_rd),
        .evt_raw(evt_raw), .evt_mask(evt_mask)
    );

    // Interrupt: any flag that is both raised and unmasked.
    assign irq = |(evt_raw & evt_mask);

endmodule

// File: rtl/i2c_tgt_chk.sv
// Module: i2c_tgt_chk
// Temporal checks on the I2C target, attached to the top by bind below.
module i2c_tgt_chk
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enabled,
    input logic              scl_pull,
    input logic              sda_pull,
    input logic              rx_pend,
    input logic              tx_pend,
    input logic              first_flag,
    input logic              start_det,
    input logic              stop_det,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [EV_NUM-1:0] evt_raw
);
    // R12
    disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> (!scl_pull && !sda_pull));

    // R4
    stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> (rx_pend || tx_pend));

    // R3
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_pend && tx_pend));

    // R5
    first_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_flag |-> rx_pend);

    // R8
    data_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_pend) |=> evt_raw[EV_DATA]);

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RI_MIS && reg_wdata[EV_START] && !start_det)
        |=> !evt_raw[EV_START]);

    // R10
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RI_MIS && reg_wdata[EV_STOP] && !stop_det)
        |=> !evt_raw[EV_STOP]);

endmodule

bind i2c_target_stretch i2c_tgt_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .rx_pend(rx_pend), .tx_pend(tx_pend),
    .first_flag(first_flag), .start_det(start_det), .stop_det(stop_det),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .evt_raw(evt_raw)
);

// File: tb/tb_i2c_target_stretch.sv
// Directed bench: a bus-controller model drives the open-drain lines while
// a host model services the register port.
module tb_i2c_target_stretch;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam logic [6:0] OWN = 7'h3A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl_pull, sda_pull, irq;
    logic       scl_line, sda_line;
    int         checks = 0;
    int         errors = 0;

    assign scl_line = ~(m_scl_low | scl_pull);
    assign sda_line = ~(m_sda_low | sda_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_target_stretch dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_status(input int idx);
        logic [7:0] v;
        v = 8'h00;
        while (!v[idx]) host_read(3'd2, v);
    endtask

    task automatic hold_low_check(input string req, input int n);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!scl_line) lows++;
        end
        chk(req, lows, n);
    endtask

    task automatic wait_scl_high();
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b1; wait_clk(Q);
        m_scl_low = 1'b1; wait_clk(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; wait_clk(Q);
        m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q);
        m_sda_low = 1'b0; wait_clk(Q);
    endtask

    task automatic m_wbit(input logic b);
        m_sda_low = ~b; wait_clk(Q);
        m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q);
        m_scl_low = 1'b1; wait_clk(Q);
    endtask

    task automatic m_rbit(output logic b);
        m_sda_low = 1'b0; wait_clk(Q);
        m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q);
        b = sda_line;
        m_scl_low = 1'b1; wait_clk(Q);
    endtask

    task automatic m_write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(b);
        ack = ~b;
    endtask

    task automatic m_read_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            d[i] = b;
        end
        m_wbit(~give_ack);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            host_read(3'(a), v);
            chk($sformatf("R11 reg %0d after reset", a), v, 0);
        end
        chk("R11 irq after reset", irq, 0);
        chk("R11 line pulls after reset", {scl_pull, sda_pull}, 0);
    endtask

    task automatic t_enable();
        host_write(3'd0, {1'b0, OWN});
        host_write(3'd1, 8'h01);
        host_write(3'd7, 8'h01);
        host_write(3'd4, 8'h07);
        host_write(3'd6, 8'h07);
    endtask

    task automatic t_wrong_addr();
        logic ack;
        logic [7:0] v;
        m_start();
        m_write_byte({7'h15, 1'b0}, ack);
        chk("R1 no ACK for foreign address", ack, 0);
        m_stop();
        host_read(3'd5, v);
        chk("R8 start and stop flags raised", v, 8'h06);
        chk("R9 irq with flags unmasked", irq, 1);
        host_write(3'd4, 8'h05);
        host_read(3'd6, v);
        chk("R9 masked view is raw AND mask", v, 8'h04);
        host_write(3'd4, 8'h00);
        chk("R9 irq low with all masked", irq, 0);
        host_write(3'd4, 8'h07);
        host_write(3'd6, 8'h02);
        host_read(3'd5, v);
        chk("R10 clear only the START flag", v, 8'h04);
        host_write(3'd6, 8'h07);
        host_read(3'd5, v);
        chk("R10 clear all flags", v, 8'h00);
    endtask

    task automatic t_write_txn();
        logic ack;
        logic [7:0] v;
        m_start();
        m_write_byte({OWN, 1'b0}, ack);
        chk("R1 address ACK on match", ack, 1);
        fork
            m_write_byte(8'hA5, ack);
            begin
                wait_status(0);
                host_read(3'd2, v);
                chk("R5 first-byte flag on first byte", v, 8'h05);
                hold_low_check("R4 SCL held until data read", 40);
                host_read(3'd3, v);
                chk("R6 data register holds received byte", v, 8'hA5);
                host_read(3'd2, v);
                chk("R5 status cleared by data read", v, 8'h00);
            end
        join
        chk("R4 ACK on received byte", ack, 1);
        fork
            m_write_byte(8'h5C, ack);
            begin
                wait_status(0);
                host_read(3'd2, v);
                chk("R5 no first-byte flag on second byte", v, 8'h01);
                host_read(3'd3, v);
                chk("R6 second received byte", v, 8'h5C);
            end
        join
        m_stop();
        host_read(3'd5, v);
        chk("R8 data flag after receive", v[0], 1);
        host_read(3'd3, v);
        chk("R6 data value persists after STOP", v, 8'h5C);
        host_write(3'd6, 8'h07);
    endtask

    task automatic t_read_txn();
        logic ack;
        logic b;
        logic [7:0] v, got;
        m_start();
        m_write_byte({OWN, 1'b1}, ack);
        chk("R1 read address ACK", ack, 1);
        fork
            m_read_byte(got, 1'b1);
            begin
                wait_status(1);
                hold_low_check("R3 SCL held until data write", 40);
                host_write(3'd3, 8'hC3);
            end
        join
        chk("R3 first sent byte MSB first", got, 8'hC3);
        fork
            m_read_byte(got, 1'b0);
            begin
                wait_status(1);
                chk("R7 ACK raises new transmit request", 1, 1);
                host_write(3'd3, 8'h96);
            end
        join
        chk("R7 second sent byte", got, 8'h96);
        host_read(3'd2, v);
        chk("R7 no request after NACK", v, 8'h00);
        m_rbit(b);
        chk("R7 target silent after NACK", b, 1);
        m_stop();
        host_read(3'd3, v);
        chk("R6 data register holds last host write", v, 8'h96);
        host_write(3'd6, 8'h07);
    endtask

    task automatic t_enables();
        logic ack;
        logic [7:0] v;
        host_write(3'd7, 8'h00);
        m_start();
        m_write_byte({OWN, 1'b0}, ack);
        chk("R2 no ACK with target function off", ack, 0);
        m_stop();
        host_write(3'd7, 8'h01);
        host_write(3'd1, 8'h00);
        m_start();
        m_write_byte({OWN, 1'b0}, ack);
        chk("R2 no ACK with run off", ack, 0);
        m_stop();
        host_read(3'd5, v);
        chk("R8 no flags while disabled", v, 8'h00);
        host_write(3'd1, 8'h01);
    endtask

    task automatic t_disable_mid();
        logic ack;
        logic [7:0] v;
        m_start();
        m_write_byte({OWN, 1'b0}, ack);
        fork
            m_write_byte(8'h3C, ack);
            begin
                wait_status(0);
                host_write(3'd1, 8'h00);
                @(negedge clk);
                chk("R12 lines released after disable", {scl_pull, sda_pull}, 0);
                host_read(3'd2, v);
                chk("R12 requests dropped after disable", v, 8'h00);
            end
        join
        m_stop();
        host_write(3'd1, 8'h01);
        host_write(3'd6, 8'h07);
    endtask

    task automatic t_clear_vs_start();
        logic [7:0] v;
        wait_clk(Q);
        @(negedge clk);
        m_sda_low = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h02;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
        host_read(3'd5, v);
        chk("R10 START event beats same-cycle clear", v[1], 1);
        wait_clk(Q);
        m_sda_low = 1'b0;
        wait_clk(Q);
        host_write(3'd6, 8'h07);
        host_read(3'd5, v);
        chk("R10 clear with no event", v, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_enable();
        t_wrong_addr();
        t_write_txn();
        t_read_txn();
        t_enables();
        t_disable_mid();
        t_clear_vs_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule